// File: doc/BRIEF.md
# Register-Triggered Pixel Plot and Rectangle Fill Engine

This block is a small drawing accelerator on a processor's register write bus. It writes 16-bit pixels into a 1920 by 1080 framebuffer through a single write port that uses a valid/ready handshake. There is no command register. Software loads a colour and an X coordinate, and the store to the Y coordinate draws one pixel. In the same way, software loads a rectangle's start X and its two extents, and the store to the rectangle's start Y launches a fill. The fill sweeps the region one row at a time.

The framebuffer is linear. The word address of pixel (x, y) is y*1920 + x. It is built from two shifts and a subtraction, so no general multiplier is needed. One output register drives the write port. A one-entry holding slot keeps a plot that arrives while a fill is running, and the plot goes out once that fill has finished. The busy output tells software when all requested drawing has reached the framebuffer.

Top module: `pixfill_engine`

## Requirements
- R1: The pixel data written is the 16-bit colour value exactly as stored: red in bits 15:11, green in bits 10:5, blue in bits 4:0.
- R2: Register select codes are: 0 colour, 1 plot X, 2 plot Y, 3 fill start X, 4 fill start Y, 5 fill width minus one, 6 fill height minus one. A store to select 2 plots one pixel at (stored X, written Y) in the stored colour. A store to select 0 or 1 alone issues no framebuffer write.
- R3: Every framebuffer write uses address y*1920 + x for its pixel (x, y).
- R4: A plot with X of 1920 or more, or Y of 1080 or more, issues no write, and busy stays low.
- R5: A store to select 4 starts a fill with the stored start X, the written start Y and the stored extents, where each extent register holds its size minus one. The fill issues exactly one write per pixel. X increases fastest, and rows follow from the top row down.
- R6: A fill is clipped at column 1919 and row 1079. A fill whose start lies off screen issues no write.
- R7: Busy is low after reset. It is high from the cycle after any accepted trigger until the last resulting write has been accepted.
- R8: A plot stored while a fill runs is held and written after the fill's last pixel. A second plot stored during the same fill replaces the held one.
- R9: A store to select 4 while a fill runs is ignored. The running fill neither changes nor restarts.
- R10: While a write is offered and ready is low, valid stays high and the address and data stay unchanged.
- R11: During and right after reset, valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 16 | Register write data |
| fb_valid | output | 1 | Framebuffer write offered |
| fb_ready | input | 1 | Framebuffer accepts the offered write |
| fb_addr | output | 21 | Framebuffer pixel address |
| fb_data | output | 16 | RGB 5-6-5 pixel value |
| busy | output | 1 | Drawing work is pending or in flight |

## Verification
The bench drives several kinds of input:
- Plots at the four extreme corners. These separate a correct row stride from one that is wrong only by a row-dependent term.
- Seeded random plots that are sometimes off screen. These test the range discard on each axis on its own.
- Small fills, and fills that straddle the right and bottom edges. These show the row-major order and the clipping, where an off-by-one at the end of a row or column would be visible.
- Plots stored while a fill runs, and a fill trigger stored while a fill runs. These tell apart a design that queues correctly from one that interleaves pixels or restarts the fill.

Ready is toggled at random throughout, so the stall behaviour is exercised at the same time as the drawing.

// File: rtl/pixfill_pkg.sv
package pixfill_pkg;
  localparam int unsigned SCR_W  = 1920;
  localparam int unsigned SCR_H  = 1080;
  localparam int unsigned PIX_W  = 16;
  localparam int unsigned CRD_W  = 16;
  localparam int unsigned POS_W  = $clog2(SCR_W);
  localparam int unsigned FB_AW  = $clog2(SCR_W * SCR_H);
  // Row stride 1920 = 2^11 - 2^7, so a row offset is two shifts and a subtract
  localparam int unsigned SHL_HI = 11;
  localparam int unsigned SHL_LO = 7;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_COLOUR = 3'd0,
    SEL_PLOT_X = 3'd1,
    SEL_PLOT_Y = 3'd2,
    SEL_FILL_X = 3'd3,
    SEL_FILL_Y = 3'd4,
    SEL_FILL_W = 3'd5,
    SEL_FILL_H = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  function automatic logic [FB_AW-1:0] fb_addr_of(input logic [POS_W-1:0] x,
                                                  input logic [POS_W-1:0] y);
    logic [FB_AW-1:0] yy;
    yy = FB_AW'(y);
    return (yy << SHL_HI) - (yy << SHL_LO) + FB_AW'(x);
  endfunction
endpackage

// File: rtl/pixfill_regs.sv
module pixfill_regs
  import pixfill_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PIX_W-1:0] wr_data,
  output logic [PIX_W-1:0] colour,
  output logic             plot_go,
  output logic [CRD_W-1:0] plot_x,
  output logic [CRD_W-1:0] plot_y,
  output logic             fill_go,
  output logic [CRD_W-1:0] fill_x,
  output logic [CRD_W-1:0] fill_y,
  output logic [CRD_W-1:0] fill_w,
  output logic [CRD_W-1:0] fill_h
);
  reg_sel_e sel;
  logic en_col, en_px, en_fx, en_fw, en_fh;
  logic [PIX_W-1:0] col_q;
  logic [CRD_W-1:0] px_q, fx_q, fw_q, fh_q;

  assign sel = reg_sel_e'(wr_sel);

  always_comb begin
    en_col  = 1'b0;
    en_px   = 1'b0;
    en_fx   = 1'b0;
    en_fw   = 1'b0;
    en_fh   = 1'b0;
    plot_go = 1'b0;
    fill_go = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_COLOUR: en_col  = 1'b1;
        SEL_PLOT_X: en_px   = 1'b1;
        SEL_PLOT_Y: plot_go = 1'b1;
        SEL_FILL_X: en_fx   = 1'b1;
        SEL_FILL_Y: fill_go = 1'b1;
        SEL_FILL_W: en_fw   = 1'b1;
        SEL_FILL_H: en_fh   = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      px_q  <= '0;
      fx_q  <= '0;
      fw_q  <= '0;
      fh_q  <= '0;
    end else begin
      if (en_col) col_q <= wr_data;
      if (en_px)  px_q  <= CRD_W'(wr_data);
      if (en_fx)  fx_q  <= CRD_W'(wr_data);
      if (en_fw)  fw_q  <= CRD_W'(wr_data);
      if (en_fh)  fh_q  <= CRD_W'(wr_data);
    end
  end

  assign colour = col_q;
  assign plot_x = px_q;
  assign plot_y = CRD_W'(wr_data);
  assign fill_x = fx_q;
  assign fill_y = CRD_W'(wr_data);
  assign fill_w = fw_q;
  assign fill_h = fh_q;
endmodule

// File: rtl/pixfill_walker.sv
module pixfill_walker
  import pixfill_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CRD_W-1:0] xs,
  input  logic [CRD_W-1:0] ys,
  input  logic [CRD_W-1:0] xl,
  input  logic [CRD_W-1:0] yl,
  input  logic [PIX_W-1:0] col_in,
  input  logic             adv,
  output logic             active,
  output logic [POS_W-1:0] cur_x,
  output logic [POS_W-1:0] cur_y,
  output logic [PIX_W-1:0] col
);
  localparam logic [CRD_W:0]   X_LIM = (CRD_W+1)'(SCR_W - 1);
  localparam logic [CRD_W:0]   Y_LIM = (CRD_W+1)'(SCR_H - 1);
  localparam logic [POS_W-1:0] X_MAX = POS_W'(SCR_W - 1);
  localparam logic [POS_W-1:0] Y_MAX = POS_W'(SCR_H - 1);

  logic             act_q, act_d;
  logic [POS_W-1:0] x_q, x_d, y_q, y_d, xb_q, xb_d, xe_q, xe_d, ye_q, ye_d;
  logic [PIX_W-1:0] col_q, col_d;
  logic [CRD_W:0]   x_sum, y_sum;
  logic             on_screen, launch, load_en;

  assign x_sum     = {1'b0, xs} + {1'b0, xl};
  assign y_sum     = {1'b0, ys} + {1'b0, yl};
  assign on_screen = (xs < CRD_W'(SCR_W)) && (ys < CRD_W'(SCR_H));
  assign launch    = start && !act_q && on_screen;
  assign load_en   = launch || (act_q && adv);

  always_comb begin
    act_d = act_q;
    x_d   = x_q;
    y_d   = y_q;
    xb_d  = xb_q;
    xe_d  = xe_q;
    ye_d  = ye_q;
    col_d = col_q;
    if (launch) begin
      act_d = 1'b1;
      x_d   = xs[POS_W-1:0];
      y_d   = ys[POS_W-1:0];
      xb_d  = xs[POS_W-1:0];
      xe_d  = (x_sum > X_LIM) ? X_MAX : x_sum[POS_W-1:0];
      ye_d  = (y_sum > Y_LIM) ? Y_MAX : y_sum[POS_W-1:0];
      col_d = col_in;
    end else if (act_q && adv) begin
      if (x_q == xe_q) begin
        if (y_q == ye_q) begin
          act_d = 1'b0;
        end else begin
          x_d = xb_q;
          y_d = y_q + 1'b1;
        end
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      xb_q  <= '0;
      xe_q  <= '0;
      ye_q  <= '0;
      col_q <= '0;
    end else if (load_en) begin
      act_q <= act_d;
      x_q   <= x_d;
      y_q   <= y_d;
      xb_q  <= xb_d;
      xe_q  <= xe_d;
      ye_q  <= ye_d;
      col_q <= col_d;
    end
  end

  assign active = act_q;
  assign cur_x  = x_q;
  assign cur_y  = y_q;
  assign col    = col_q;

  // R5/R6: the sweep stays inside its clipped rectangle and on screen
  a_r6_walk_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (x_q >= xb_q) && (x_q <= xe_q) && (y_q <= ye_q) && (xe_q <= X_MAX) && (ye_q <= Y_MAX));
  // R5: within a row, each accepted pixel moves one column right
  a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && adv && (x_q != xe_q) |=> (x_q == $past(x_q) + 1'b1) && (y_q == $past(y_q)));
  // R9: a trigger during a running fill leaves its bounds and colour untouched
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && start |=> (xb_q == $past(xb_q)) && (xe_q == $past(xe_q)) && (ye_q == $past(ye_q)) && (col_q == $past(col_q)));
endmodule

// File: rtl/pixfill_engine.sv
module pixfill_engine
  import pixfill_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [PIX_W-1:0] reg_wdata,
  output logic             fb_valid,
  input  logic             fb_ready,
  output logic [FB_AW-1:0] fb_addr,
  output logic [PIX_W-1:0] fb_data,
  output logic             busy
);
  localparam logic [FB_AW-1:0] FB_LAST = FB_AW'(SCR_W * SCR_H - 1);

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [PIX_W-1:0] colour;
  logic             plot_go, fill_go;
  logic [CRD_W-1:0] plot_x, plot_y, fill_x, fill_y, fill_w, fill_h;

  pixfill_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_we),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .colour  (colour),
    .plot_go (plot_go),
    .plot_x  (plot_x),
    .plot_y  (plot_y),
    .fill_go (fill_go),
    .fill_x  (fill_x),
    .fill_y  (fill_y),
    .fill_w  (fill_w),
    .fill_h  (fill_h)
  );

  logic             walk_active, walk_adv;
  logic [POS_W-1:0] walk_x, walk_y;
  logic [PIX_W-1:0] walk_col;

  pixfill_walker u_walker (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (fill_go),
    .xs     (fill_x),
    .ys     (fill_y),
    .xl     (fill_w),
    .yl     (fill_h),
    .col_in (colour),
    .adv    (walk_adv),
    .active (walk_active),
    .cur_x  (walk_x),
    .cur_y  (walk_y),
    .col    (walk_col)
  );

  // One-entry plot holding slot
  logic             hold_v_q, hold_v_d, hold_take, plot_ok;
  logic [FB_AW-1:0] hold_a_q, hold_a_d;
  logic [PIX_W-1:0] hold_c_q, hold_c_d;

  assign plot_ok = plot_go && (plot_x < CRD_W'(SCR_W)) && (plot_y < CRD_W'(SCR_H));

  // Output stage
  logic             out_v_q, out_v_d, out_load;
  logic [FB_AW-1:0] out_a_q, out_a_d;
  logic [PIX_W-1:0] out_c_q, out_c_d;

  assign out_load  = !out_v_q || fb_ready;
  assign walk_adv  = out_load && walk_active;
  assign hold_take = out_load && !walk_active && hold_v_q;

  always_comb begin
    hold_v_d = hold_v_q;
    hold_a_d = hold_a_q;
    hold_c_d = hold_c_q;
    if (hold_take) hold_v_d = 1'b0;
    if (plot_ok) begin
      hold_v_d = 1'b1;
      hold_a_d = fb_addr_of(plot_x[POS_W-1:0], plot_y[POS_W-1:0]);
      hold_c_d = colour;
    end
  end

  always_comb begin
    out_v_d = walk_active || hold_v_q;
    out_a_d = hold_a_q;
    out_c_d = hold_c_q;
    if (walk_active) begin
      out_a_d = fb_addr_of(walk_x, walk_y);
      out_c_d = walk_col;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_v_q <= 1'b0;
      hold_a_q <= '0;
      hold_c_q <= '0;
    end else if (plot_ok || hold_take) begin
      hold_v_q <= hold_v_d;
      hold_a_q <= hold_a_d;
      hold_c_q <= hold_c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_v_q <= 1'b0;
      out_a_q <= '0;
      out_c_q <= '0;
    end else if (out_load) begin
      out_v_q <= out_v_d;
      out_a_q <= out_a_d;
      out_c_q <= out_c_d;
    end
  end

  assign fb_valid = out_v_q;
  assign fb_addr  = out_a_q;
  assign fb_data  = out_c_q;
  assign busy     = walk_active || hold_v_q || out_v_q;

  // R10: a stalled offer keeps valid, address and data
  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fb_valid && !fb_ready |=> fb_valid && $stable(fb_addr) && $stable(fb_data));
  // R3/R4: no address beyond the last pixel ever leaves the block
  a_r4_addr_on_screen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fb_valid |-> fb_addr <= FB_LAST);
  // R8: a held plot waits while the fill is sweeping
  a_r8_hold_waits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_v_q && walk_active |=> hold_v_q);
  // R2: an on-screen plot store lands in the holding slot
  a_r2_plot_captured: assert property (@(posedge clk) disable iff (!rst_sync_n)
    plot_ok |=> hold_v_q && (hold_c_q == $past(colour)));
endmodule

// File: tb/tb_pixfill_engine.sv
module tb_pixfill_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        fb_valid;
  logic        fb_ready = 1'b0;
  logic [20:0] fb_addr;
  logic [15:0] fb_data;
  logic        busy;

  pixfill_engine dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .fb_valid  (fb_valid),
    .fb_ready  (fb_ready),
    .fb_addr   (fb_addr),
    .fb_data   (fb_data),
    .busy      (busy)
  );

  always #5 clk = ~clk;

  localparam int MAXW = 4096;
  int exp_a [MAXW];
  int exp_d [MAXW];
  int got_a [MAXW];
  int got_d [MAXW];
  int n_exp = 0, n_got = 0, cmp_idx = 0;
  int n_chk = 0, n_fail = 0;
  bit ready_rand = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pix_addr(input int x, input int y);
    return y * 1920 + x;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic push_exp(input int x, input int y, input int c);
    if (n_exp < MAXW) begin
      exp_a[n_exp] = pix_addr(x, y);
      exp_d[n_exp] = c;
      n_exp++;
    end
  endtask

  task automatic push_plot(input int x, input int y, input int c);
    if (x < 1920 && y < 1080) push_exp(x, y, c);
  endtask

  task automatic push_fill(input int xs, input int ys, input int xl, input int yl, input int c);
    int xe, ye;
    if (xs >= 1920 || ys >= 1080) return;
    xe = min_i(xs + xl, 1919);
    ye = min_i(ys + yl, 1079);
    for (int y = ys; y <= ye; y++)
      for (int x = xs; x <= xe; x++)
        push_exp(x, y, c);
  endtask

  // Called right after a falling edge; the write is taken on the next rising edge
  task automatic wr_reg(input int sel, input int val);
    reg_we    = 1'b1;
    reg_sel   = 3'(sel);
    reg_wdata = 16'(val);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic compare_all(input string req);
    while (cmp_idx < n_exp) begin
      check(got_a[cmp_idx] == exp_a[cmp_idx], "R3", {req, " address"}, got_a[cmp_idx], exp_a[cmp_idx]);
      check(got_d[cmp_idx] == exp_d[cmp_idx], "R1", {req, " data"}, got_d[cmp_idx], exp_d[cmp_idx]);
      cmp_idx++;
    end
    check(n_got == n_exp, req, "write count", n_got, n_exp);
  endtask

  task automatic do_plot(input int x, input int y, input int c);
    wr_reg(0, c);
    wr_reg(1, x);
    wr_reg(2, y);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Ready pattern: mostly random stalls
  initial begin
    forever begin
      @(negedge clk);
      fb_ready = ready_rand ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Write monitor and R10 stall check, sampled between edges
  initial begin
    bit prev_stall = 1'b0;
    int prev_a = 0, prev_d = 0;
    forever begin
      @(negedge clk);
      #2;
      if (prev_stall) begin
        check(fb_valid == 1'b1, "R10", "valid dropped while stalled", int'(fb_valid), 1);
        check(int'(fb_addr) == prev_a && int'(fb_data) == prev_d, "R10",
              "offer changed while stalled", int'(fb_addr), prev_a);
      end
      prev_stall = fb_valid && !fb_ready && rst_n;
      prev_a = int'(fb_addr);
      prev_d = int'(fb_data);
      if (fb_valid && fb_ready && n_got < MAXW) begin
        got_a[n_got] = int'(fb_addr);
        got_d[n_got] = int'(fb_data);
        n_got++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin
    int x, y, c, base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(fb_valid == 1'b0, "R11", "valid in reset", int'(fb_valid), 0);
    check(busy == 1'b0, "R11", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(fb_valid == 1'b0 && busy == 1'b0, "R11", "idle after reset", int'(busy), 0);
    ready_rand = 1'b1;

    // R2: colour and X alone draw nothing
    wr_reg(0, 16'h1234);
    wr_reg(1, 7);
    repeat (5) @(negedge clk);
    check(n_got == 0, "R2", "writes from colour/X only", n_got, 0);
    check(busy == 1'b0, "R2", "busy after colour/X only", int'(busy), 0);

    // R1/R3: corner plots with pure primaries
    do_plot(0, 0, 16'hF800);
    check(busy == 1'b1, "R7", "busy after plot store", int'(busy), 1);
    push_plot(0, 0, 16'hF800);
    wait_idle();
    do_plot(1919, 1079, 16'h07E0); push_plot(1919, 1079, 16'h07E0); wait_idle();
    do_plot(1919, 0, 16'h001F);    push_plot(1919, 0, 16'h001F);    wait_idle();
    do_plot(0, 1079, 16'hFFFF);    push_plot(0, 1079, 16'hFFFF);    wait_idle();
    compare_all("R2 corner plots");

    // R4: off-screen plots are dropped
    do_plot(1920, 0, 16'hAAAA);
    check(busy == 1'b0, "R4", "busy after X=1920 plot", int'(busy), 0);
    do_plot(0, 1080, 16'hAAAA);
    check(busy == 1'b0, "R4", "busy after Y=1080 plot", int'(busy), 0);
    do_plot(65535, 65535, 16'hAAAA);
    repeat (5) @(negedge clk);
    compare_all("R4 off-screen plots");

    // R2/R3/R4: random plots, some off screen
    for (int i = 0; i < 200; i++) begin
      c = int'($urandom % 65536);
      if (($urandom % 8) == 0) begin
        x = int'($urandom % 4096);
        y = int'($urandom % 4096);
      end else begin
        x = int'($urandom % 1920);
        y = int'($urandom % 1080);
      end
      do_plot(x, y, c);
      push_plot(x, y, c);
      wait_idle();
    end
    compare_all("R2 random plots");

    // R5: small fill, 4 wide and 3 tall
    wr_reg(0, 16'h5AA5);
    wr_reg(3, 10);
    wr_reg(5, 3);
    wr_reg(6, 2);
    wr_reg(4, 20);
    check(busy == 1'b1, "R7", "busy after fill store", int'(busy), 1);
    push_fill(10, 20, 3, 2, 16'h5AA5);
    wait_idle();
    compare_all("R5 small fill");

    // R6: fill clipped at both edges, then an off-screen fill
    wr_reg(0, 16'h0F0F);
    wr_reg(3, 1917);
    wr_reg(5, 5);
    wr_reg(6, 5);
    wr_reg(4, 1078);
    push_fill(1917, 1078, 5, 5, 16'h0F0F);
    wait_idle();
    wr_reg(3, 1920);
    wr_reg(4, 0);
    check(busy == 1'b0, "R6", "busy after off-screen fill", int'(busy), 0);
    repeat (5) @(negedge clk);
    compare_all("R6 clipped fill");

    // R8: plots during a fill are held; the later one wins
    wr_reg(0, 16'h3333);
    wr_reg(3, 100);
    wr_reg(5, 7);
    wr_reg(6, 7);
    wr_reg(4, 100);
    push_fill(100, 100, 7, 7, 16'h3333);
    do_plot(5, 6, 16'h4444);
    do_plot(9, 11, 16'h5555);
    check(busy == 1'b1, "R8", "busy while fill and held plot", int'(busy), 1);
    push_plot(9, 11, 16'h5555);
    wait_idle();
    compare_all("R8 plot during fill");

    // R9: re-trigger during a fill is ignored
    wr_reg(0, 16'h6666);
    wr_reg(3, 300);
    wr_reg(5, 5);
    wr_reg(6, 5);
    wr_reg(4, 40);
    push_fill(300, 40, 5, 5, 16'h6666);
    wr_reg(3, 0);
    wr_reg(5, 0);
    wr_reg(6, 0);
    wr_reg(4, 0);
    wait_idle();
    compare_all("R9 retrigger ignored");

    // R5/R6: random fills, some near the edges
    for (int i = 0; i < 6; i++) begin
      base = int'($urandom % 2);
      x = base ? 1900 + int'($urandom % 20) : int'($urandom % 1900);
      y = base ? 1065 + int'($urandom % 15) : int'($urandom % 1065);
      c = int'($urandom % 65536);
      wr_reg(0, c);
      wr_reg(3, x);
      wr_reg(5, int'($urandom % 16));
      wr_reg(6, int'($urandom % 16));
      push_fill(x, y, int'(u_w()), int'(u_h()), c);
      wr_reg(4, y);
      wait_idle();
    end
    compare_all("R5 random fills");

    check(busy == 1'b0 && fb_valid == 1'b0, "R7", "idle at end", int'(busy), 0);
    finish_run();
  end

  // Extents last written to the width and height registers, tracked at the bench side
  logic [15:0] w_shadow = '0, h_shadow = '0;
  always @(negedge clk) begin
    if (reg_we && reg_sel == 3'd5) w_shadow <= reg_wdata;
    if (reg_we && reg_sel == 3'd6) h_shadow <= reg_wdata;
  end
  function automatic logic [15:0] u_w();
    return reg_sel == 3'd5 && reg_we ? reg_wdata : w_shadow;
  endfunction
  function automatic logic [15:0] u_h();
    return h_shadow;
  endfunction
endmodule